// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers five interrupt sources for a small 8-bit processor core. The sources are:

- a falling edge on an external pin;
- overflow pulses from two timers;
- an overflow pulse from a time base;
- a conversion-done pulse from an analog-to-digital converter.

Each source has a latched request flag and an enable bit. A single global enable gates all of them. The flags, the enables and the global enable live in two byte-wide registers. Software reads and writes these registers through a simple one-cycle port.

When the global enable, a source's enable and that source's flag are all set, the controller picks one source. It only does so while the core reports that its return stack has room. It then raises a one-cycle request strobe and presents that source's fixed vector address. The lowest address wins when several sources qualify.

The core answers with a one-cycle acknowledge. The controller then clears the serviced flag and the global enable in hardware, so that a second interrupt cannot nest inside the first. A separate wake output tells the power-down logic that an enabled request is waiting. The wake output ignores the global enable.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset both registers read 0x00, `irq_req` is 0 and `wake` is 0.
- R2: `irq_req` pulses only when the global enable, the source enable and the source flag are all 1. The pulse comes one clock after that condition is seen, and it lasts exactly one cycle.
- R3: While `stack_full` is 1, no request strobe is issued. A pending request is issued once `stack_full` returns to 0.
- R4: An `irq_ack` that arrives while a request is outstanding clears the served source's flag and the global enable. An `irq_ack` with nothing outstanding changes nothing.
- R5: A flag is set by its event even when its enable is 0. It stays set until that source is serviced or until software writes 0 to it. Software may also write 1 to a flag.
- R6: When several enabled flags are pending, service order is external, timer 0, timer 1, time base, converter.
- R7: `wake` is 1 exactly when some flag is set and its enable is 1. The global enable has no effect on `wake`.
- R8: The external flag is set by a high-to-low transition of `ext_pin`, after a two-flop synchroniser. A low-to-high transition sets nothing.
- R9: The vectors are 0x04 (external), 0x08 (timer 0), 0x0C (timer 1), 0x10 (time base) and 0x14 (converter). `irq_vector` holds its value from the strobe until the acknowledge.
- R10: When an event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R11: Register 0 (`reg_addr`=0) has this layout, and bit 7 reads 0:
  - bit 0: global enable;
  - bits 1, 2, 3: enables for external, timer 0, timer 1;
  - bits 4, 5, 6: flags for external, timer 0, timer 1.
- R12: Register 1 (`reg_addr`=1) has this layout, and all other bits read 0:
  - bits 0 and 1: enables for time base and converter;
  - bits 4 and 5: flags for time base and converter.
- R13: `reg_rdata` shows the addressed register combinationally.
- R14: At most one request is outstanding. No new strobe is issued before the previous one has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select (0 or 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse |
| tbase_ovf | input | 1 | Time-base overflow pulse |
| adc_done | input | 1 | Conversion-complete pulse |
| stack_full | input | 1 | Core return stack is full |
| irq_req | output | 1 | One-cycle interrupt entry strobe |
| irq_vector | output | 8 | Vector address of the chosen source |
| irq_ack | input | 1 | One-cycle service acknowledge from the core |
| wake | output | 1 | Enabled request pending; wakes the core from power-down |

## Verification
The bench sets every flag at once and then re-enables the global bit after each service. A design with the priority reversed, or one that left a flag uncleared after service, would return the vectors out of order or repeat one of them.

It holds the stack-full input high while a request is eligible, and it delays the acknowledge by several cycles while a second request is eligible. A controller that ignored the stack, or that issued a new strobe before being acknowledged, would produce a strobe the scoreboard does not expect.

It lands an event and a software clear on the same flag in the same cycle, where the wrong priority loses the event. It also pulses the acknowledge with nothing outstanding, which a careless design would take as a reason to drop the global enable.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int NSRC   = 5;
  localparam int IDX_W  = 3;
  localparam int REG_W  = 8;
  localparam int R0_SRC = 3;  // sources whose bits sit in register 0

  typedef enum logic [IDX_W-1:0] {
    SRC_EXT   = 3'd0,
    SRC_TMR0  = 3'd1,
    SRC_TMR1  = 3'd2,
    SRC_TBASE = 3'd3,
    SRC_ADC   = 3'd4
  } src_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } hs_state_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic fall
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      assign sync_d = pin;
    end else begin : g_many
      assign sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall = prev_q & ~sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/irq_flag_regs.sv
module irq_flag_regs
  import irq_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [NSRC-1:0]  event_set,
  input  logic [NSRC-1:0]  svc_clr,
  input  logic             gie_clr,
  output logic             gie,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flag,
  output logic [REG_W-1:0] reg_rdata
);
  logic wr0, wr1;
  logic gie_q, gie_d;
  logic [NSRC-1:0] en_q, en_d, flag_q, flag_d;

  assign wr0 = reg_wr & ~reg_addr;
  assign wr1 = reg_wr &  reg_addr;

  // Global enable: service clears it, a software write in the same cycle wins.
  always_comb begin
    gie_d = gie_q;
    if (gie_clr) gie_d = 1'b0;
    if (wr0)     gie_d = reg_wdata[0];
  end

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      localparam bit IN_R1 = (i >= R0_SRC);
      localparam int LOC   = IN_R1 ? (i - R0_SRC) : i;
      localparam int EN_B  = IN_R1 ? LOC : (LOC + 1);
      localparam int FL_B  = 4 + LOC;
      logic wr_me;
      assign wr_me = IN_R1 ? wr1 : wr0;

      always_comb begin
        en_d[i] = en_q[i];
        if (wr_me) en_d[i] = reg_wdata[EN_B];
      end

      // Order: service clear, then software write, then hardware set on top.
      always_comb begin
        flag_d[i] = flag_q[i];
        if (svc_clr[i])   flag_d[i] = 1'b0;
        if (wr_me)        flag_d[i] = reg_wdata[FL_B];
        if (event_set[i]) flag_d[i] = 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  logic [REG_W-1:0] r0_view, r1_view;
  assign r0_view = {1'b0, flag_q[2:0], en_q[2:0], gie_q};
  assign r1_view = {2'b00, flag_q[4:3], 2'b00, en_q[4:3]};
  assign reg_rdata = reg_addr ? r1_view : r0_view;

  assign gie  = gie_q;
  assign en   = en_q;
  assign flag = flag_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_ctrl_pkg::*;
(
  input  logic [NSRC-1:0]  req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  // Lowest index wins: scan downward so the last hit is the smallest.
  always_comb begin
    valid = |req;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 4,
  parameter int VEC_STEP    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             ext_pin,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             tbase_ovf,
  input  logic             adc_done,
  input  logic             stack_full,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vector,
  input  logic             irq_ack,
  output logic             wake
);
  import irq_ctrl_pkg::*;

  logic            ext_fall;
  logic [NSRC-1:0] evt, en_w, flag_w, elig, svc_clr;
  logic            gie_w, arb_valid, take, done;
  logic [IDX_W-1:0] arb_idx;

  hs_state_e        st_q, st_d;
  logic             req_q, req_d;
  logic [IDX_W-1:0] idx_q;
  logic             idx_ld;
  logic             pend_q;

  irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin), .fall(ext_fall)
  );

  assign evt = {adc_done, tbase_ovf, tmr1_ovf, tmr0_ovf, ext_fall};

  irq_flag_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .event_set(evt), .svc_clr(svc_clr), .gie_clr(done),
    .gie(gie_w), .en(en_w), .flag(flag_w), .reg_rdata(reg_rdata)
  );

  assign elig = flag_w & en_w & {NSRC{gie_w}};

  irq_arbiter u_arb (.req(elig), .valid(arb_valid), .idx(arb_idx));

  // Handshake: one strobe, then wait for the acknowledge.
  assign take   = (st_q == ST_IDLE) & arb_valid & ~stack_full;
  assign done   = (st_q == ST_WAIT) & irq_ack;
  assign idx_ld = take;

  always_comb begin
    st_d  = st_q;
    req_d = take;
    case (st_q)
      ST_IDLE: if (take) st_d = ST_WAIT;
      ST_WAIT: if (irq_ack) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    svc_clr = '0;
    if (done) svc_clr[idx_q] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_ld) idx_q <= arb_idx;
  end

  assign pend_q     = (st_q == ST_WAIT);
  assign irq_req    = req_q;
  assign irq_vector = VEC_W'(VEC_BASE + int'(idx_q) * VEC_STEP);
  assign wake       = |(flag_w & en_w);
endmodule

module irq_vector_ctrl_chk #(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter int NSRC     = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vector,
  input logic             irq_ack,
  input logic             stack_full,
  input logic             reg_wr,
  input logic             reg_addr,
  input logic             gie,
  input logic [NSRC-1:0]  flags,
  input logic             pending
);
  a_r3_no_entry_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |=> !irq_req);

  a_r2_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  a_r14_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !irq_ack) |=> !irq_req);

  a_r4_ack_drops_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && irq_ack && !(reg_wr && !reg_addr)) |=> !gie);

  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !irq_ack) |=> ((flags & $past(flags)) == $past(flags)));

  a_r9_vector_legal: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (int'(irq_vector) >= VEC_BASE
                 && int'(irq_vector) <= VEC_BASE + (NSRC - 1) * VEC_STEP
                 && ((int'(irq_vector) - VEC_BASE) % VEC_STEP) == 0));

  a_r9_vector_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !irq_req) |-> $stable(irq_vector));
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(
  .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .NSRC(5)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vector(irq_vector),
  .irq_ack(irq_ack), .stack_full(stack_full), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .gie(gie_w), .flags(flag_w), .pending(pend_q)
);

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_addr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       ext_pin = 1'b1;
  logic       tmr0_ovf = 1'b0, tmr1_ovf = 1'b0, tbase_ovf = 1'b0, adc_done = 1'b0;
  logic       stack_full = 1'b0;
  logic       irq_req, wake;
  logic [7:0] irq_vector;
  logic       ack_auto = 1'b0, ack_man = 1'b0;
  logic       irq_ack;

  int checks = 0, errors = 0;
  int ack_delay = 0;
  int ack_cnt = 0;
  logic [7:0] exp_q[$];

  assign irq_ack = ack_auto | ack_man;

  always #5 clk = ~clk;

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
    .tmr0_ovf(tmr0_ovf), .tmr1_ovf(tmr1_ovf), .tbase_ovf(tbase_ovf),
    .adc_done(adc_done), .stack_full(stack_full), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_ack(irq_ack), .wake(wake)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic expect_irq(input logic [7:0] vec);
    exp_q.push_back(vec);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic a, input logic [7:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic pulse(input logic [4:0] m);
    @(negedge clk);
    if (m[0]) ext_pin = 1'b0;
    tmr0_ovf = m[1]; tmr1_ovf = m[2]; tbase_ovf = m[3]; adc_done = m[4];
    @(negedge clk);
    tmr0_ovf = 0; tmr1_ovf = 0; tbase_ovf = 0; adc_done = 0;
  endtask

  // Monitor: pops expected vectors and acknowledges.
  initial begin
    forever begin
      @(negedge clk);
      ack_auto = 1'b0;
      if (ack_cnt > 0) begin
        ack_cnt--;
        if (ack_cnt == 0) ack_auto = 1'b1;
      end
      if (irq_req === 1'b1) begin
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R2/R3/R14 unexpected strobe actual=%02h expected=none", irq_vector);
        end else begin
          chk("R9/R6 vector", irq_vector, exp_q.pop_front());
        end
        if (ack_delay == 0) ack_auto = 1'b1;
        else ack_cnt = ack_delay;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    rd("R1 reg0", 1'b0, 8'h00);
    rd("R1 reg1", 1'b1, 8'h00);
    chk("R1 req", {7'd0, irq_req}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R5/R12 flag latches with enable off; R7 no wake
    pulse(5'b01000);
    rd("R5 R12 tbase flag", 1'b1, 8'h10);
    chk("R7 wake off", {7'd0, wake}, 8'h00);
    wr(1'b1, 8'h11);
    idle(4);
    chk("R7 wake w/o gie", {7'd0, wake}, 8'h01);
    wr(1'b1, 8'h00);
    rd("R5 sw clear", 1'b1, 8'h00);

    // R2: gie + flag but enable off -> nothing
    wr(1'b0, 8'h21);
    idle(6);
    rd("R2 R11 no req", 1'b0, 8'h21);
    expect_irq(8'h08);
    wr(1'b0, 8'h25);
    idle(6);
    rd("R4 flag+gie cleared", 1'b0, 8'h04);

    // R4 stray ack ignored
    wr(1'b0, 8'h01);
    @(negedge clk); ack_man = 1'b1;
    @(negedge clk); ack_man = 1'b0;
    rd("R4 stray ack", 1'b0, 8'h01);

    // R8 falling edge of pin
    wr(1'b0, 8'h03);
    expect_irq(8'h04);
    @(negedge clk); ext_pin = 1'b0;
    idle(8);
    rd("R8 ext served", 1'b0, 8'h02);
    @(negedge clk); ext_pin = 1'b1;
    idle(6);
    rd("R8 rising ignored", 1'b0, 8'h02);

    // R6 priority with all five pending
    wr(1'b1, 8'h03);
    wr(1'b0, 8'h0E);
    pulse(5'b11111);
    @(negedge clk); ext_pin = 1'b1;
    idle(4);
    rd("R11 all flags r0", 1'b0, 8'h7E);
    rd("R12 all flags r1", 1'b1, 8'h33);
    expect_irq(8'h04); wr(1'b0, 8'h7F); idle(6);
    expect_irq(8'h08); wr(1'b0, 8'h6F); idle(6);
    expect_irq(8'h0C); wr(1'b0, 8'h4F); idle(6);
    expect_irq(8'h10); wr(1'b0, 8'h0F); idle(6);
    expect_irq(8'h14); wr(1'b0, 8'h0F); idle(6);
    rd("R6 r0 drained", 1'b0, 8'h0E);
    rd("R6 r1 drained", 1'b1, 8'h03);
    chk("R7 wake drained", {7'd0, wake}, 8'h00);

    // R3 stack full holds off entry
    @(negedge clk); stack_full = 1'b1;
    pulse(5'b00010);
    wr(1'b0, 8'h2F);
    idle(10);
    chk("R3 R7 wake while held", {7'd0, wake}, 8'h01);
    expect_irq(8'h08);
    @(negedge clk); stack_full = 1'b0;
    idle(6);
    rd("R3 served after release", 1'b0, 8'h0E);

    // R14 late acknowledge: no second strobe
    ack_delay = 6;
    wr(1'b0, 8'h0F);
    expect_irq(8'h08);
    pulse(5'b00110);
    idle(14);
    rd("R14 one outstanding", 1'b0, 8'h4E);
    ack_delay = 0;
    expect_irq(8'h0C);
    wr(1'b0, 8'h4F);
    idle(6);
    rd("R14 second served", 1'b0, 8'h0E);

    // R10 event beats same-cycle software clear
    @(negedge clk);
    tmr1_ovf = 1'b1; reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 8'h0E;
    @(negedge clk);
    tmr1_ovf = 1'b0; reg_wr = 1'b0;
    rd("R10 set wins", 1'b0, 8'h4E);
    wr(1'b0, 8'h00);
    rd("R13 r0 readback", 1'b0, 8'h00);

    idle(4);
    chk("scoreboard empty", 8'(exp_q.size()), 8'h00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule